// File: doc/BRIEF.md
# Arithmetic Right Shift with Carry

This unit takes a signed 32-bit word and a shift-count register, shifts the word right while copying its sign bit into every vacated position, and reports through a carry flag whether precision was lost: the flag rises only when the word is negative and at least one 1 bit fell off the low end. Only the low six bits of the count register matter. Counts from 32 to 63 do not wrap. They fill the whole result with the sign.

A request is presented with a valid strobe. The shifted word and the carry are registered and appear one clock later, together with a done strobe. Between requests the outputs keep their last values.

Top module: `sra_carry_unit`

## Requirements
- R1: Only bits [5:0] of `in_amount` affect the outputs; bits [31:6] are ignored.
- R2: With a count of 0, `out_result` equals `in_value` and `out_carry` is 0.
- R3: With a count n from 1 to 31, `out_result` is `in_value` shifted right by n with bit 31 copied into the n vacated upper positions.
- R4: With count bit 5 set (counts 32 to 63), `out_result` is all ones when `in_value[31]` is 1 and all zeros otherwise.
- R5: For a negative `in_value` and a count n from 1 to 31, `out_carry` is 1 exactly when any of `in_value[n-1:0]` is 1.
- R6: For a negative `in_value` with count bit 5 set, `out_carry` is 1 exactly when any of `in_value[30:0]` is 1.
- R7: For a non-negative `in_value` (bit 31 is 0), `out_carry` is 0 for every count.
- R8: `out_done` is 1 in the cycle after a cycle with `in_valid` high and 0 otherwise; without `in_valid`, `out_result` and `out_carry` keep their values.
- R9: While `rst_n` is low, `out_done`, `out_result` and `out_carry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_value | input | 32 | Signed word to shift |
| in_amount | input | 32 | Shift-count register; low six bits used |
| out_done | output | 1 | Result valid, one cycle after the request |
| out_result | output | 32 | Shifted word |
| out_carry | output | 1 | Lost-precision flag |

## Verification
Every count from 0 to 63 is applied to a set of words: zero, one, the most negative value, all ones, the largest positive value, and mixed bit patterns. The negative words with few low bits set show the carry tracking exactly which bits leave the word. The most negative value shows that the sign bit alone never raises carry under a full fill. Each sweep is repeated with junk in the upper count bits, so that any use of those bits shows up as a wrong result. Idle cycles with changed inputs check that the outputs hold and that done stays low.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int unsigned SRA_DATA_W = 32;

  function automatic int unsigned sra_shift_bits(input int unsigned width);
    return $clog2(width);
  endfunction
endpackage

// File: rtl/sra_barrel.sv
module sra_barrel #(
  parameter int unsigned DATA_W  = sra_pkg::SRA_DATA_W,
  parameter int unsigned SHIFT_W = sra_pkg::sra_shift_bits(DATA_W)
) (
  input  logic [DATA_W-1:0]  value,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               full_fill,
  output logic [DATA_W-1:0]  shifted
);
  logic              sign_bit;
  logic [DATA_W-1:0] stage [0:SHIFT_W];

  assign sign_bit = value[DATA_W-1];
  assign stage[0] = value;

  // One conditional power-of-two step per count bit, sign filled
  for (genvar k = 0; k < SHIFT_W; k++) begin : g_step
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = shamt[k] ? {{STEP{sign_bit}}, stage[k][DATA_W-1:STEP]}
                                 : stage[k];
  end

  assign shifted = full_fill ? {DATA_W{sign_bit}} : stage[SHIFT_W];
endmodule

// File: rtl/sra_loss_detect.sv
module sra_loss_detect #(
  parameter int unsigned DATA_W  = sra_pkg::SRA_DATA_W,
  parameter int unsigned SHIFT_W = sra_pkg::sra_shift_bits(DATA_W)
) (
  input  logic [DATA_W-1:0]  value,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               full_fill,
  output logic               lost
);
  logic [DATA_W-1:0] drop_mask;

  // drop_mask has a 1 at every position that leaves the word
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    localparam logic [SHIFT_W-1:0] IDX = SHIFT_W'(i);
    if (i == DATA_W - 1) begin : g_top
      assign drop_mask[i] = 1'b0;
    end else begin : g_low
      assign drop_mask[i] = full_fill | (IDX < shamt);
    end
  end

  assign lost = value[DATA_W-1] & (|(value & drop_mask));
endmodule

// File: rtl/sra_carry_unit.sv
module sra_carry_unit #(
  parameter int unsigned DATA_W = sra_pkg::SRA_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_value,
  input  logic [DATA_W-1:0] in_amount,
  output logic              out_done,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry
);
  localparam int unsigned SHIFT_W = sra_pkg::sra_shift_bits(DATA_W);

  logic [SHIFT_W-1:0] shamt;
  logic               full_fill;
  logic [DATA_W-1:0]  shifted;
  logic               lost;

  logic [DATA_W-1:0]  result_q, result_d;
  logic               carry_q, carry_d;
  logic               done_q, done_d;

  // R1: only the count bits up to and including the fill bit are decoded
  assign shamt     = in_amount[SHIFT_W-1:0];
  assign full_fill = in_amount[SHIFT_W];

  sra_barrel #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_barrel (
    .value     (in_value),
    .shamt     (shamt),
    .full_fill (full_fill),
    .shifted   (shifted)
  );

  sra_loss_detect #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_loss (
    .value     (in_value),
    .shamt     (shamt),
    .full_fill (full_fill),
    .lost      (lost)
  );

  always_comb begin
    result_d = result_q;
    carry_d  = carry_q;
    done_d   = in_valid;
    if (in_valid) begin
      result_d = shifted;
      carry_d  = lost;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      carry_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      carry_q  <= carry_d;
      done_q   <= done_d;
    end
  end

  assign out_result = result_q;
  assign out_carry  = carry_q;
  assign out_done   = done_q;

  a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_amount[SHIFT_W:0] == '0)
    |=> (out_result == $past(in_value)) && !out_carry);

  a_r4_full_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_amount[SHIFT_W]
    |=> out_result == {DATA_W{$past(in_value[DATA_W-1])}});

  a_r5_carry_negative: assert property (@(posedge clk) disable iff (!rst_n)
    out_done && out_carry |-> out_result[DATA_W-1]);

  a_r7_nonneg_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_value[DATA_W-1] |=> !out_carry);

  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done && $stable(out_result) && $stable(out_carry));
endmodule

// File: tb/test_sra_carry_unit.sv
`timescale 1ns/1ps
module test_sra_carry_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_value;
  logic [31:0] in_amount;
  logic        out_done;
  logic [31:0] out_result;
  logic        out_carry;

  int checks = 0;
  int errors = 0;

  sra_carry_unit i_sra_carry_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_amount(in_amount), .out_done(out_done), .out_result(out_result),
    .out_carry(out_carry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_model(input logic [31:0] v, input logic [31:0] a,
                              output logic [31:0] res, output logic car);
    int n;
    logic [31:0] mask;
    n = int'(a[5:0]);
    if (n >= 32) begin
      res = v[31] ? 32'hFFFF_FFFF : 32'h0;
      car = v[31] && (v[30:0] != 31'h0);
    end else begin
      res  = 32'($signed(v) >>> n);
      mask = 32'((64'h1 << n) - 64'h1);
      car  = v[31] && ((v & mask) != 32'h0);
    end
  endtask

  task automatic apply(input logic [31:0] v, input logic [31:0] a);
    logic [31:0] er;
    logic ec;
    string rq;
    expect_model(v, a, er, ec);
    in_valid  = 1'b1;
    in_value  = v;
    in_amount = a;
    @(negedge clk);
    in_valid = 1'b0;
    if (a[5:0] == 6'd0) rq = "R2";
    else if (a[5]) rq = "R4/R6";
    else rq = "R3/R5";
    if (a[31:6] != 26'h0) rq = {rq, "/R1"};
    check(out_done == 1'b1, "R8 done", {31'h0, out_done}, 32'h1);
    check(out_result == er, rq, out_result, er);
    check(out_carry == ec, v[31] ? rq : "R7", {31'h0, out_carry}, {31'h0, ec});
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pats [10];
    logic [31:0] hold_r;
    logic        hold_c;
    pats = '{32'h0, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
             32'h8000_0001, 32'hF0F0_F0F0, 32'h1234_5678, 32'hC000_8000,
             32'h8400_0000};
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_value = '0;
    in_amount = '0;
    repeat (3) @(negedge clk);
    check(out_done == 1'b0 && out_result == 32'h0 && out_carry == 1'b0,
          "R9 reset", out_result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (pats[p]) begin
      for (int n = 0; n < 64; n++) begin
        apply(pats[p], 32'(n));
        apply(pats[p], {26'h2AA_AAA5 ^ 26'(p), 6'(n)});
      end
    end
    // R8: idle cycles keep the outputs and drop done
    apply(32'h8000_0003, 32'd1);
    hold_r = out_result;
    hold_c = out_carry;
    in_value  = 32'h0000_0000;
    in_amount = 32'd0;
    @(negedge clk);
    check(out_done == 1'b0, "R8 idle done", {31'h0, out_done}, 32'h0);
    check(out_result == hold_r, "R8 hold result", out_result, hold_r);
    check(out_carry == hold_c, "R8 hold carry", {31'h0, out_carry}, {31'h0, hold_c});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule